// File: doc/BRIEF.md
# Pulse-Width Argmax Selector

This block looks at a group of pulse-width-encoded signals that all rise at the start of a shared frame. It reports which one stayed high the longest. Each input's pulse is timed in clock cycles from the frame-start strobe. The measured widths are then compared pair by pair. An input becomes a candidate when no other input is strictly wider. A cascade of lower-index masks then keeps only one candidate, so the result is a one-hot vector. A balanced tree of two-input maximum stages, with equal depth on every path, produces the widest width itself.

A frame opens with a single-cycle `frame_start` strobe. The inputs are sampled on the `FRAME_LEN` rising clock edges that follow the strobe edge. One cycle after the last sample, the one-hot result, the maximum width and `result_valid` are registered. They stay unchanged until the next strobe, which clears `result_valid` and starts a new measurement. A strobe that arrives during a frame abandons that frame and restarts the measurement.

Top module: `pw_argmax`

## Requirements
- R1: After reset, `result_valid`, `onehot_out` and `max_width_out` are all zero.
- R2: An input's width is the number of consecutive samples at logic 1, counted from the first sample edge after the strobe. Counting stops at the first sample at logic 0. A later return to 1 within the same frame is not counted.
- R3: An input that stays high through the whole frame measures exactly `FRAME_LEN`. The count saturates there.
- R4: While `result_valid` is 1, exactly one bit of `onehot_out` is set. That bit i belongs to an input whose width is the largest of all inputs.
- R5: When several inputs share the largest width, the set bit is the lowest-indexed of them. This also holds when every width is zero, which gives bit 0.
- R6: `max_width_out` equals the largest measured width, which is also the width of the input marked in `onehot_out`.
- R7: Take the strobe edge as edge 0. `result_valid` is 0 through edge `FRAME_LEN` and becomes 1 on edge `FRAME_LEN`+1.
- R8: Once valid, the outputs hold their values, whatever the pulse inputs do, until the next strobe. `result_valid` is 0 in the cycle after a strobe edge.
- R9: A strobe during a running frame discards that frame's counts. The result reflects only the samples taken after the latest strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Single-cycle strobe that opens a measurement frame |
| pulse_in | input | N_IN | Pulse-width-encoded inputs, one bit per channel |
| onehot_out | output | N_IN | One-hot index of the widest pulse |
| max_width_out | output | CNT_W | Width of the widest pulse, in clock cycles |
| result_valid | output | 1 | High from frame end until the next strobe |

## Verification
The assertions assume that the pulse inputs are synchronous to `clk`. They also assume `CNT_W` is wide enough to hold `FRAME_LEN`, so the saturation bound and the check that the winner's width matches the tree output are meaningful. The hold property is written only for cycles without a strobe, because a strobe is allowed to clear the result at any time. The stimulus changes `frame_start` and `pulse_in` only on falling clock edges. Each frame is driven as a rising-at-start pulse per channel. Extra patterns cover a gap followed by a re-rise, activity between frames, and a strobe in the middle of a frame. All of these stay inside the sampled-input assumption.

// File: rtl/pw_argmax_pkg.sv
// Package: shared types and sizing helpers for the pulse-width argmax.
// Assumes nothing beyond integer parameter values >= 1.
package pw_argmax_pkg;

    // Frame sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } frame_state_e;

    // Width of a counter able to hold values 0..n-1, never below one bit.
    function automatic int span_bits(input int n);
        int b;
        b = $clog2(n);
        return (b < 1) ? 1 : b;
    endfunction

    // Number of leaves of a balanced binary tree covering n inputs.
    function automatic int tree_leaves(input int n);
        return 1 << $clog2(n);
    endfunction

endpackage

// File: rtl/pw_width_meter.sv
// Width meter: times one pulse input from the frame strobe until its first
// low sample, and saturates at FRAME_LEN.
// Assumes pulse_i is synchronous to clk and that sample_i is high only on
// the sample edges of a frame.
module pw_width_meter #(
    parameter int CNT_W     = 8,
    parameter int FRAME_LEN = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             sample_i,
    input  logic             pulse_i,
    output logic [CNT_W-1:0] width_o
);

    localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(FRAME_LEN);

    logic             armed_q;
    logic [CNT_W-1:0] width_q;

    // Count while armed and high; disarm on the first low sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            width_q <= '0;
        end else if (restart_i) begin
            armed_q <= 1'b1;
            width_q <= '0;
        end else if (sample_i && armed_q) begin
            if (pulse_i) begin
                if (width_q != SAT_VAL) begin
                    width_q <= width_q + 1'b1;
                end
            end else begin
                armed_q <= 1'b0;
            end
        end
    end

    assign width_o = width_q;

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !restart_i) |=> $stable(width_q)); // R2

    AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        width_q <= SAT_VAL); // R3

endmodule

// File: rtl/pw_pair_rank.sv
// Pairwise rank: one subtractor per input pair gives both comparison
// directions. Each input's comparison results are ANDed into a candidate flag.
// A prefix cascade of inverted lower-index candidates leaves a single bit set.
// Purely combinational; assumes N >= 1.
module pw_pair_rank #(
    parameter int N     = 4,
    parameter int CNT_W = 8
) (
    input  logic [N-1:0][CNT_W-1:0] width_i,
    output logic [N-1:0]            onehot_o
);

    logic [N-1:0] beats [N];   // beats[a][b]: a is at least as wide as b
    logic [N-1:0] cand;
    logic [N:0]   lower_any;

    for (genvar a = 0; a < N; a++) begin : g_row
        for (genvar b = 0; b < N; b++) begin : g_col
            if (b > a) begin : g_pair
                logic [CNT_W:0] diff;
                // One comparator per pair: borrow means a is narrower.
                assign diff        = {1'b0, width_i[a]} - {1'b0, width_i[b]};
                assign beats[a][b] = ~diff[CNT_W];
                assign beats[b][a] = diff[CNT_W] | (diff == '0);
            end else if (b == a) begin : g_self
                assign beats[a][b] = 1'b1;
            end
        end
        // Candidate only if every comparison involving it favours it.
        assign cand[a] = &beats[a];
    end

    // Tie cascade: a candidate is masked by any lower-index candidate.
    assign lower_any[0] = 1'b0;
    for (genvar k = 0; k < N; k++) begin : g_cascade
        assign lower_any[k+1] = lower_any[k] | cand[k];
        assign onehot_o[k]    = cand[k] & ~lower_any[k];
    end

endmodule

// File: rtl/pw_max_tree.sv
// Max tree: balanced binary tree of two-input maximum stages, with unused
// leaves padded with zero so every path has log2 depth.
// Purely combinational; assumes N >= 1.
module pw_max_tree #(
    parameter int N     = 4,
    parameter int CNT_W = 8
) (
    input  logic [N-1:0][CNT_W-1:0] width_i,
    output logic [CNT_W-1:0]        max_o
);

    import pw_argmax_pkg::*;

    localparam int LEAVES = tree_leaves(N);
    localparam int NODES  = 2 * LEAVES - 1;

    logic [CNT_W-1:0] node [NODES];

    // Leaves: real inputs first, zero padding after.
    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < N) begin : g_real
            assign node[LEAVES-1+k] = width_i[k];
        end else begin : g_pad
            assign node[LEAVES-1+k] = '0;
        end
    end

    // Internal nodes in heap order: each keeps the larger child.
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_stage
        assign node[k] = (node[2*k+1] > node[2*k+2]) ? node[2*k+1] : node[2*k+2];
    end

    assign max_o = node[0];

endmodule

// File: rtl/pw_argmax.sv
// Pulse-width argmax top: frame sequencer, one width meter per input,
// pairwise rank with tie cascade, balanced max tree and result registers.
// Assumes pulse_in is synchronous to clk, frame_start is a one-cycle strobe,
// FRAME_LEN >= 2 and CNT_W can represent FRAME_LEN.
module pw_argmax #(
    parameter int N_IN      = 4,
    parameter int CNT_W     = 8,
    parameter int FRAME_LEN = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [N_IN-1:0]   pulse_in,
    output logic [N_IN-1:0]   onehot_out,
    output logic [CNT_W-1:0]  max_width_out,
    output logic              result_valid
);

    import pw_argmax_pkg::*;

    localparam int              FC_W     = span_bits(FRAME_LEN);
    localparam logic [FC_W-1:0] LAST_CNT = FC_W'(FRAME_LEN - 1);

    frame_state_e                 state_q;
    logic [FC_W-1:0]              frame_cnt_q;
    logic                         sample_en;
    logic [N_IN-1:0][CNT_W-1:0]   widths;
    logic [N_IN-1:0]              win;
    logic [CNT_W-1:0]             tree_max;
    logic [N_IN-1:0]              onehot_q;
    logic [CNT_W-1:0]             maxw_q;
    logic                         valid_q;
    logic                         capture;

    assign sample_en = (state_q == ST_RUN);
    assign capture   = (state_q == ST_DONE) && !frame_start;

    // Frame sequencer: FRAME_LEN sample edges after the strobe, then done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            frame_cnt_q <= '0;
        end else if (frame_start) begin
            state_q     <= ST_RUN;
            frame_cnt_q <= '0;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (frame_cnt_q == LAST_CNT) begin
                        state_q <= ST_DONE;
                    end else begin
                        frame_cnt_q <= frame_cnt_q + 1'b1;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // One width meter per pulse input.
    for (genvar i = 0; i < N_IN; i++) begin : g_meter
        pw_width_meter #(
            .CNT_W     (CNT_W),
            .FRAME_LEN (FRAME_LEN)
        ) u_meter (
            .clk       (clk),
            .rst_n     (rst_n),
            .restart_i (frame_start),
            .sample_i  (sample_en),
            .pulse_i   (pulse_in[i]),
            .width_o   (widths[i])
        );
    end

    pw_pair_rank #(
        .N     (N_IN),
        .CNT_W (CNT_W)
    ) u_rank (
        .width_i  (widths),
        .onehot_o (win)
    );

    pw_max_tree #(
        .N     (N_IN),
        .CNT_W (CNT_W)
    ) u_tree (
        .width_i (widths),
        .max_o   (tree_max)
    );

    // Result registers: capture at frame end, clear on strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            onehot_q <= '0;
            maxw_q   <= '0;
            valid_q  <= 1'b0;
        end else if (frame_start) begin
            valid_q  <= 1'b0;
        end else if (capture) begin
            onehot_q <= win;
            maxw_q   <= tree_max;
            valid_q  <= 1'b1;
        end
    end

    assign onehot_out    = onehot_q;
    assign max_width_out = maxw_q;
    assign result_valid  = valid_q;

    // Width of the rank winner, used only to cross-check the max tree.
    logic [CNT_W-1:0] sel_width;
    always_comb begin
        sel_width = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (win[i]) sel_width = sel_width | widths[i];
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ($countones(onehot_q) == 1)); // R4

    AST_WINNER_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (sel_width == tree_max)); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !frame_start) |=> (valid_q && $stable(onehot_q) && $stable(maxw_q))); // R8

    AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !valid_q); // R8

    AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> !valid_q); // R7

endmodule

// File: tb/pw_argmax_test.sv
module pw_argmax_test;

    localparam int N  = 4;
    localparam int CW = 5;
    localparam int F  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic [N-1:0]  pulse_in = '0;
    logic [N-1:0]  onehot_out;
    logic [CW-1:0] max_width_out;
    logic          result_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int wv [N];
    bit glitch = 1'b0;

    always #5 clk = ~clk;

    pw_argmax #(.N_IN(N), .CNT_W(CW), .FRAME_LEN(F)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start   (frame_start),
        .pulse_in      (pulse_in),
        .onehot_out    (onehot_out),
        .max_width_out (max_width_out),
        .result_valid  (result_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one frame from the current wv/glitch; ends after edge F+1.
    task automatic run_frame(input string req);
        @(negedge clk);
        frame_start = 1'b1;
        pulse_in = '0;
        for (int t = 1; t <= F; t++) begin
            @(negedge clk);
            frame_start = 1'b0;
            for (int i = 0; i < N; i++) begin
                pulse_in[i] = (t <= wv[i]) || (glitch && (t > wv[i] + 2));
            end
            if (t == 1) chk({req, " R7 valid low in frame"}, int'(result_valid), 0);
        end
        @(negedge clk);
        pulse_in = '0;
        chk({req, " R7 valid low at edge F"}, int'(result_valid), 0);
        @(negedge clk);
    endtask

    // Check the held result against widths computed from wv.
    task automatic check_result(input string req);
        int eff [N];
        int mx;
        int idx;
        mx = 0;
        idx = 0;
        for (int i = 0; i < N; i++) begin
            eff[i] = (wv[i] > F) ? F : wv[i];
            if (eff[i] > mx) mx = eff[i];
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (eff[i] == mx) idx = i;
        end
        chk({req, " R7 valid"}, int'(result_valid), 1);
        chk({req, " R4 R5 onehot"}, int'(onehot_out), 1 << idx);
        chk({req, " R6 max width"}, int'(max_width_out), mx);
    endtask

    initial begin
        int lv [4];
        lv[0] = 0; lv[1] = 6; lv[2] = 13; lv[3] = F + 2;

        repeat (3) @(negedge clk);
        chk("R1 valid after reset", int'(result_valid), 0);
        chk("R1 onehot after reset", int'(onehot_out), 0);
        chk("R1 max after reset", int'(max_width_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep all level combinations: ties, zeros, saturation (R2 R3 R4 R5 R6).
        for (int code = 0; code < 256; code++) begin
            for (int i = 0; i < N; i++) wv[i] = lv[(code >> (2 * i)) & 3];
            glitch = 1'b0;
            run_frame("sweep R2");
            check_result("sweep R2");
        end

        // All zero: lowest index wins (R5).
        for (int i = 0; i < N; i++) wv[i] = 0;
        run_frame("zero R5");
        check_result("zero R5");

        // All beyond frame: saturation to F (R3).
        for (int i = 0; i < N; i++) wv[i] = F + 5;
        run_frame("sat R3");
        check_result("sat R3");

        // Re-rise after a gap is not counted (R2).
        wv[0] = 4; wv[1] = 9; wv[2] = 9; wv[3] = 2;
        glitch = 1'b1;
        run_frame("rerise R2");
        check_result("rerise R2");
        glitch = 1'b0;

        // Hold between frames under pulse activity (R8).
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            pulse_in = N'(k * 5 + 3);
            chk("R8 hold valid", int'(result_valid), 1);
            chk("R8 hold onehot", int'(onehot_out), 2);
            chk("R8 hold max", int'(max_width_out), 9);
        end

        // Strobe mid-frame restarts the measurement (R9); strobe clears (R8).
        @(negedge clk);
        frame_start = 1'b1;
        pulse_in = '1;
        @(negedge clk);
        frame_start = 1'b0;
        chk("R8 strobe clears valid", int'(result_valid), 0);
        repeat (5) @(negedge clk);
        wv[0] = 3; wv[1] = 1; wv[2] = 2; wv[3] = 0;
        run_frame("restart R9");
        check_result("restart R9");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule